// File: doc/BRIEF.md
# Controller Interrupt Status Unit

This unit gathers single-cycle event pulses from the command, data and FIFO paths of a card host controller. Each pulse sets a sticky bit in a 20-bit raw status register. Software clears bits by writing ones to that register. A 20-bit mask selects which pending events may raise the interrupt. A global enable bit in a control register gates the single registered interrupt line.

Two summary flags group the pending raw events. One flag covers command-path errors and the other covers data-path errors. Both flags are driven as output ports and can also be read through the register bus.

Register writes take effect at the clock edge. Read data is a combinational function of the address and the current register state. The circuits that produce the event pulses are outside this block.

Top module: `irq_status_unit`

## Requirements
- R1: A 1 on bit i of `evt_pulse` sets raw status bit i at the next clock edge, and the bit stays set after the pulse ends until software clears it.
- R2: A write to word address 3 (raw status) clears every raw bit whose write-data bit is 1. Write-data bits that are 0 leave their raw bits unchanged. Writing all ones clears every pending event.
- R3: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R4: Word address 1 holds a 20-bit mask; bits 31:20 read as 0. Word address 2 reads the raw status ANDed with the mask.
- R5: Word address 0 is the control word. Only bit 4 (interrupt enable) is stored, and all other bits read as 0. While bit 4 is 0, `irq_out` is low.
- R6: `irq_out` is registered. It is high in the cycle after a clock edge at which the enable bit was set and at least one masked status bit was pending before that edge. It falls one cycle after the masked status becomes empty.
- R7: The command-error flag is the OR of raw bits 1 (response error), 6 (response CRC error), 8 (response timeout) and 12 (hardware-locked error). It drives `cmd_err` and reads as bit 0 of word address 4.
- R8: The data-error flag is the OR of raw bits 7 (data CRC), 9 (data read timeout), 10 (starvation timeout), 11 (FIFO over/underrun), 12 (hardware-locked), 13 (start-bit error) and 15 (end-bit error). It drives `dat_err` and reads as bit 1 of word address 4.
- R9: The event bit map is fixed as follows:
  - bits 0, 2, 3: card detect, command done, transfer over
  - bits 4, 5: transmit request, receive request
  - bit 14: auto-command done
  - bits 19:16: four SDIO interrupts
  - all other bits: as listed in R7 and R8

  All 20 bits are stored and read back at their positions, and raw bits 31:20 read as 0.
- R10: After reset, the raw status, the mask and the enable bit are all 0 and `irq_out` is low. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 20 | Event pulses, one bit per event source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Registered interrupt request |
| cmd_err | output | 1 | Command-error summary |
| dat_err | output | 1 | Data-error summary |

## Verification
Four properties are checked on every cycle:
- a pulsed bit is set after the edge;
- a cleared bit with no coincident pulse is zero after the edge;
- a cleared enable forces the line low one cycle later;
- an empty masked status drops the line one cycle later.

Several behaviours can only be shown by bench scenarios:
- the set-over-clear priority;
- the exact membership of both error groups, checked by pulsing each of the 20 bits alone;
- the read-back widths of the mask and control words;
- the all-ones clear.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int EVT_W  = 20;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam int B_CARD_DET   = 0;
  localparam int B_RESP_ERR   = 1;
  localparam int B_CMD_DONE   = 2;
  localparam int B_XFER_OVER  = 3;
  localparam int B_TX_REQ     = 4;
  localparam int B_RX_REQ     = 5;
  localparam int B_RESP_CRC   = 6;
  localparam int B_DATA_CRC   = 7;
  localparam int B_RESP_TMO   = 8;
  localparam int B_RD_TMO     = 9;
  localparam int B_STARVE_TMO = 10;
  localparam int B_FIFO_RUN   = 11;
  localparam int B_HW_LOCK    = 12;
  localparam int B_START_BIT  = 13;
  localparam int B_AUTO_DONE  = 14;
  localparam int B_END_BIT    = 15;
  localparam int B_SDIO_LO    = 16;

  localparam logic [EVT_W-1:0] CMD_GRP =
      (EVT_W'(1) << B_RESP_ERR) | (EVT_W'(1) << B_RESP_CRC) |
      (EVT_W'(1) << B_RESP_TMO) | (EVT_W'(1) << B_HW_LOCK);

  localparam logic [EVT_W-1:0] DAT_GRP =
      (EVT_W'(1) << B_DATA_CRC) | (EVT_W'(1) << B_RD_TMO) |
      (EVT_W'(1) << B_STARVE_TMO) | (EVT_W'(1) << B_FIFO_RUN) |
      (EVT_W'(1) << B_HW_LOCK) | (EVT_W'(1) << B_START_BIT) |
      (EVT_W'(1) << B_END_BIT);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SUM   = ADDR_W'(4);

  localparam int IEN_BIT = 4;
endpackage

// File: rtl/isu_raw_reg.sv
module isu_raw_reg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] raw_q;
  logic [W-1:0] raw_d;
  logic [W-1:0] bit_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      bit_en[i] = evt_i[i] | (clr_we_i & clr_bits_i[i]);
      raw_d[i]  = evt_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         raw_q[i] <= 1'b0;
      else if (bit_en[i]) raw_q[i] <= raw_d[i];
    end
  end

  assign raw_o = raw_q;

  p_set_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_o & $past(evt_i)) == $past(evt_i)))
    else $error("raw bit not set after pulse");

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && ((clr_bits_i & ~evt_i) != '0))
      |=> ((raw_o & $past(clr_bits_i & ~evt_i)) == '0))
    else $error("raw bit survived clear");
endmodule

// File: rtl/isu_cfg_regs.sv
module isu_cfg_regs
  import isu_pkg::*;
#(
  parameter int W  = 20,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  mask_o,
  output logic          ien_o
);
  logic [W-1:0] mask_q;
  logic         ien_q;
  logic         mask_en;
  logic         ctrl_en;

  always_comb begin
    mask_en = wr_i && (addr_i == AW'(A_MASK));
    ctrl_en = wr_i && (addr_i == AW'(A_CTRL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien_q <= 1'b0;
    else if (ctrl_en) ien_q <= wdata_i[IEN_BIT];
  end

  assign mask_o = mask_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/isu_err_group.sv
module isu_err_group
  import isu_pkg::*;
#(
  parameter int W = 20
) (
  input  logic [W-1:0] raw_i,
  output logic         cmd_err_o,
  output logic         dat_err_o
);
  always_comb begin
    cmd_err_o = |(raw_i & CMD_GRP);
    dat_err_o = |(raw_i & DAT_GRP);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int W  = EVT_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_pulse,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_out,
  output logic          cmd_err,
  output logic          dat_err
);
  logic [W-1:0] raw;
  logic [W-1:0] mask;
  logic [W-1:0] masked;
  logic         ien;
  logic         clr_we;
  logic         irq_q;
  logic         irq_d;
  logic         unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:W];
  assign clr_we = bus_wr && (bus_addr == AW'(A_RAW));

  isu_raw_reg #(.W(W)) u_raw (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse),
    .clr_we_i(clr_we), .clr_bits_i(bus_wdata[W-1:0]), .raw_o(raw)
  );

  isu_cfg_regs #(.W(W), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata[W-1:0]), .mask_o(mask), .ien_o(ien)
  );

  isu_err_group #(.W(W)) u_grp (
    .raw_i(raw), .cmd_err_o(cmd_err), .dat_err_o(dat_err)
  );

  assign masked = raw & mask;

  always_comb irq_d = ien & (|masked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_out = irq_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      AW'(A_CTRL):  bus_rdata[IEN_BIT] = ien;
      AW'(A_MASK):  bus_rdata[W-1:0]   = mask;
      AW'(A_MSTAT): bus_rdata[W-1:0]   = masked;
      AW'(A_RAW):   bus_rdata[W-1:0]   = raw;
      AW'(A_SUM):   bus_rdata[1:0]     = {dat_err, cmd_err};
      default:      bus_rdata          = '0;
    endcase
  end

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |=> !irq_out)
    else $error("irq raised while disabled");

  p_irq_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & mask) == '0) |=> !irq_out)
    else $error("irq raised with empty masked status");
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam logic [W-1:0] CMDG = 20'h01142;
  localparam logic [W-1:0] DATG = 20'h0BE80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [W-1:0] evt_pulse;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out, cmd_err, dat_err;

  irq_status_unit dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .cmd_err(cmd_err), .dat_err(dat_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit        irq;
    bit        cmd;
    bit        dat;
    bit        chk_rd;
    bit [31:0] rd;
    string     tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] m_raw, m_mask;
  logic         m_en, m_irq;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {27'd0, m_en, 4'd0};
      3'd1: return {12'd0, m_mask};
      3'd2: return {12'd0, m_raw & m_mask};
      3'd3: return {12'd0, m_raw};
      3'd4: return {30'd0, |(m_raw & DATG), |(m_raw & CMDG)};
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input logic [W-1:0] evt, input bit wr,
                      input logic [2:0] a, input logic [31:0] wd,
                      input bit chk, input string tag);
    exp_t it;
    @(negedge clk);
    evt_pulse = evt; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    m_irq = m_en & (|(m_raw & m_mask));
    if (wr && a == 3'd3) m_raw = m_raw & ~wd[W-1:0];
    m_raw = m_raw | evt;
    if (wr && a == 3'd1) m_mask = wd[W-1:0];
    if (wr && a == 3'd0) m_en = wd[4];
    it.irq = m_irq;
    it.cmd = |(m_raw & CMDG);
    it.dat = |(m_raw & DATG);
    it.chk_rd = chk;
    it.rd = model_read(a);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step('0, 1'b0, a, 32'd0, 1'b1, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    step('0, 1'b1, a, d, 1'b0, tag);
  endtask

  task automatic pulse(input logic [W-1:0] e, input string tag);
    step(e, 1'b0, 3'd3, 32'd0, 1'b1, tag);
  endtask

  // monitor: compares outputs after each edge against queued expectations
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      total++;
      if (irq_out !== it.irq) begin
        bad++;
        $display("FAIL %s irq_out act=%0b exp=%0b", it.tag, irq_out, it.irq);
      end
      total++;
      if (cmd_err !== it.cmd) begin
        bad++;
        $display("FAIL %s cmd_err act=%0b exp=%0b", it.tag, cmd_err, it.cmd);
      end
      total++;
      if (dat_err !== it.dat) begin
        bad++;
        $display("FAIL %s dat_err act=%0b exp=%0b", it.tag, dat_err, it.dat);
      end
      if (it.chk_rd) begin
        total++;
        if (bus_rdata !== it.rd) begin
          bad++;
          $display("FAIL %s rdata act=%h exp=%h", it.tag, bus_rdata, it.rd);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_pulse = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_raw = '0; m_mask = '0; m_en = 1'b0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R10");

    // R5 only the enable bit is stored
    wr(3'd0, 32'hFFFF_FFFF, "R5");
    rd(3'd0, "R5");
    // R10 mask zero: event with enable set raises nothing
    pulse(20'h00004, "R1");
    rd(3'd3, "R1");
    rd(3'd3, "R10");
    // R4 masked view and R6 registered irq
    wr(3'd1, 32'h0000_0004, "R4");
    rd(3'd2, "R4");
    rd(3'd2, "R6");
    // R5 enable cleared drops irq
    wr(3'd0, 32'h0000_0000, "R5");
    rd(3'd0, "R5");
    rd(3'd0, "R5");
    // R2 selective clear
    pulse(20'h00030, "R1");
    wr(3'd3, 32'h0000_0010, "R2");
    rd(3'd3, "R2");
    // R3 set wins over clear
    step(20'h00020, 1'b1, 3'd3, 32'h0000_0020, 1'b1, "R3");
    rd(3'd3, "R3");
    // R2 all ones clear
    wr(3'd3, 32'hFFFF_FFFF, "R2");
    rd(3'd3, "R2");

    // R7 R8 R9 walk every bit alone
    for (int b = 0; b < W; b++) begin
      pulse(W'(1) << b, "R9");
      rd(3'd4, (CMDG[b] ? "R7" : (DATG[b] ? "R8" : "R9")));
      rd(3'd3, "R9");
      wr(3'd3, 32'hFFFF_FFFF, "R2");
    end

    // R4 R9 mask width
    wr(3'd1, 32'hFFFF_FFFF, "R4");
    rd(3'd1, "R4");
    pulse(20'hF0000, "R9");
    rd(3'd3, "R9");
    rd(3'd2, "R4");
    // R6 irq assert then fall after all-ones clear
    wr(3'd0, 32'h0000_0010, "R6");
    rd(3'd0, "R6");
    rd(3'd0, "R6");
    wr(3'd3, 32'hFFFF_FFFF, "R6");
    rd(3'd2, "R6");
    rd(3'd2, "R6");
    // R7 R8 combined hardware-locked plus data error
    pulse(20'h01080, "R8");
    rd(3'd4, "R7");
    rd(3'd2, "R6");

    @(negedge clk); evt_pulse = '0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule